// File: doc/BRIEF.md
# Auxiliary DAC Register Bank

This block stores the 12-bit control codes for three auxiliary DAC channels: channel 1 sets frequency trim, channel 2 sets amplifier gain and channel 3 sets the gain-loop level. A host loads codes through a 3-wire serial port made of an active-low chip select (`cs_n`), a shift clock (`sclk`) and a data line (`sdin`). The port pins are sampled by the block's own control clock `clk`. That clock is kept separate from the main converter clock, so channel updates are still accepted when the converter clock is stopped.

A small state machine frames each transfer. It has three states:
- **IDLE**: waits for a falling edge on `cs_n` and then moves to **SHIFT**.
- **SHIFT**: takes one bit on every rising edge of `sclk`. When `cs_n` rises after exactly 16 bits, it moves to **LOAD**. When `cs_n` rises after any other bit count, it goes straight back to **IDLE** and the word is dropped.
- **LOAD**: issues a single-cycle write to the addressed retention register and returns to **IDLE**.

The output stage applies the power mode `pmode` to each channel's stored code and produces the effective code and enable for that channel. Shutdown drives the outputs to zero but keeps the stored codes. Idle and standby pass the stored codes through unchanged.

Top module: `auxdac_bank`

## Requirements
- R1: A command word is 16 bits, shifted in MSB first on rising `sclk` edges while `cs_n` is low. Bits [15:12] are the address, where 1, 2 and 3 select channels 1, 2 and 3. Bits [11:0] are the code.
- R2: After reset, channel 1 holds code 1555 (0x613) and channels 2 and 3 hold 0. With `pmode` = 0 (active), `aux_en` = 3'b111.
- R3: A word is committed when `cs_n` rises after exactly 16 bits. The addressed channel's output shows the new code a few `clk` cycles later.
- R4: If `cs_n` rises after 15 bits or after 17 bits, the word is discarded and no channel changes.
- R5: A valid 16-bit word with address 0 or 4..15 changes no channel.
- R6: With `pmode` = 3 (shutdown), `aux_code` is all zero and `aux_en` is 3'b000.
- R7: With `pmode` = 1 (idle) or 2 (standby), every channel outputs its last stored code and `aux_en` = 3'b111. Outputs do not change unless a write occurs.
- R8: When `pmode` leaves shutdown, each channel again outputs the code it held before shutdown.
- R9: A write received during shutdown updates only the stored code. The outputs stay zero until wake-up, and then they show the new code.
- R10: `sclk` may rest high or low between transfers. In both cases the first rising edge after `cs_n` falls carries the first bit.
- R11: A write changes only the addressed channel. Channel n appears on `aux_code[12n-1:12n-12]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock, independent of the converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial shift clock |
| sdin | input | 1 | Serial data, MSB first |
| pmode | input | 2 | Power mode: 0 active, 1 idle, 2 standby, 3 shutdown |
| aux_code | output | 36 | Effective codes, channel 1 in the low 12 bits |
| aux_enable | output | 3 | Per-channel output enable |

## Verification
The assertions assume that `pmode` is synchronous to `clk`. They also assume that the serial pins change slowly compared with `clk`, so that each `sclk` level and each `cs_n` level lasts several `clk` cycles after synchronisation. A further assumption is that no `sclk` edge coincides with a `cs_n` edge. The stimulus holds every serial level for four `clk` cycles and inserts settling gaps around `cs_n` edges. It changes `pmode` only between transfers, on the falling edge of `clk`.

// File: rtl/auxdac_pkg.sv
package auxdac_pkg;
    localparam int N_CH   = 3;
    localparam int CODE_W = 12;
    localparam int ADDR_W = 4;
    localparam int WORD_W = ADDR_W + CODE_W;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_IDLE   = 2'd1,
        PM_STBY   = 2'd2,
        PM_SHDN   = 2'd3
    } pmode_t;

    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_SHIFT = 2'd1,
        SP_LOAD  = 2'd2
    } sp_state_t;

    // per-channel reset codes, channel 1 in the low slice
    localparam logic [N_CH*CODE_W-1:0] AUX_RST =
        {CODE_W'(0), CODE_W'(0), CODE_W'(1555)};
endpackage

// File: rtl/auxdac_sync.sv
module auxdac_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/auxdac_serial_fsm.sv
module auxdac_serial_fsm
    import auxdac_pkg::*;
#(
    parameter int WORD_BITS = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_s,
    input  logic                 sclk_s,
    input  logic                 sdin_s,
    output logic                 wr_en,
    output logic [WORD_BITS-1:0] wr_word
);
    localparam int CNT_MAX = WORD_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sp_state_t            state, state_nx;
    logic                 cs_q, sclk_q;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] shreg;
    logic                 cs_fall, cs_rise, sclk_rise;

    assign cs_fall   = cs_q & ~cs_n_s;
    assign cs_rise   = ~cs_q & cs_n_s;
    assign sclk_rise = sclk_s & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= state_nx;
    end

    // edge history, bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            cs_q   <= cs_n_s;
            sclk_q <= sclk_s;
            if (state == SP_IDLE && cs_fall) begin
                bit_cnt <= '0;
            end else if (state == SP_SHIFT && sclk_rise) begin
                shreg <= {shreg[WORD_BITS-2:0], sdin_s};
                if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        wr_en    = 1'b0;
        wr_word  = shreg;
        unique case (state)
            SP_IDLE:  if (cs_fall) state_nx = SP_SHIFT;
            SP_SHIFT: if (cs_rise)
                          state_nx = (bit_cnt == CNT_W'(WORD_BITS)) ? SP_LOAD : SP_IDLE;
            SP_LOAD: begin
                wr_en    = 1'b1;
                state_nx = SP_IDLE;
            end
            default:  state_nx = SP_IDLE;
        endcase
    end
endmodule

// File: rtl/auxdac_retain.sv
module auxdac_retain
    import auxdac_pkg::*;
#(
    parameter int CH    = N_CH,
    parameter int CW    = CODE_W,
    parameter int AW    = ADDR_W,
    parameter logic [CH*CW-1:0] RST = AUX_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW+CW-1:0] wr_word,
    output logic [CH*CW-1:0] stored
);
    logic [AW-1:0] addr;
    assign addr = wr_word[AW+CW-1 -: AW];

    for (genvar g = 0; g < CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stored[g*CW +: CW] <= RST[g*CW +: CW];
            else if (wr_en && addr == AW'(g + 1))
                stored[g*CW +: CW] <= wr_word[CW-1:0];
        end
    end
endmodule

// File: rtl/auxdac_gate.sv
module auxdac_gate
    import auxdac_pkg::*;
#(
    parameter int CH = N_CH,
    parameter int CW = CODE_W
) (
    input  logic [1:0]       pmode,
    input  logic [CH*CW-1:0] stored,
    output logic [CH*CW-1:0] code_o,
    output logic [CH-1:0]    en_o
);
    logic shdn;
    assign shdn = (pmode == PM_SHDN);

    for (genvar g = 0; g < CH; g++) begin : g_gate
        assign code_o[g*CW +: CW] = shdn ? '0 : stored[g*CW +: CW];
        assign en_o[g]            = ~shdn;
    end
endmodule

// File: rtl/auxdac_bank.sv
module auxdac_bank
    import auxdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   sclk,
    input  logic                   sdin,
    input  logic [1:0]             pmode,
    output logic [N_CH*CODE_W-1:0] aux_code,
    output logic [N_CH-1:0]        aux_enable
);
    logic [2:0]                 pins_s;
    logic                       wr_en;
    logic [WORD_W-1:0]          wr_word;
    logic [N_CH*CODE_W-1:0]     stored;

    auxdac_sync #(.W(3), .STAGES(2), .INIT(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdin}),
        .q     (pins_s)
    );

    auxdac_serial_fsm #(.WORD_BITS(WORD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .sdin_s  (pins_s[0]),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    auxdac_retain #(.CH(N_CH), .CW(CODE_W), .AW(ADDR_W), .RST(AUX_RST)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .stored  (stored)
    );

    auxdac_gate #(.CH(N_CH), .CW(CODE_W)) u_gate (
        .pmode  (pmode),
        .stored (stored),
        .code_o (aux_code),
        .en_o   (aux_enable)
    );
endmodule

// File: rtl/auxdac_bank_chk.sv
module auxdac_bank_chk
    import auxdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             pmode,
    input  logic [N_CH*CODE_W-1:0] aux_code,
    input  logic [N_CH-1:0]        aux_enable,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wr_word
);
    logic [ADDR_W-1:0] wa;
    assign wa = wr_word[WORD_W-1 -: ADDR_W];

    // R6
    shdn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == PM_SHDN) |-> (aux_code == '0 && aux_enable == '0));

    // R7
    awake_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode != PM_SHDN) |-> (aux_enable == '1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && pmode != PM_SHDN) |=> (pmode == PM_SHDN || $stable(aux_code)));

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3
    write_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == ADDR_W'(1)) |=>
        (pmode == PM_SHDN || aux_code[CODE_W-1:0] == $past(wr_word[CODE_W-1:0])));

    // R5
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wa == '0 || wa > ADDR_W'(N_CH))) |=>
        (pmode == PM_SHDN || $past(pmode) == PM_SHDN || $stable(aux_code)));
endmodule

bind auxdac_bank auxdac_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pmode      (pmode),
    .aux_code   (aux_code),
    .aux_enable (aux_enable),
    .wr_en      (wr_en),
    .wr_word    (wr_word)
);

// File: tb/tb_auxdac_bank.sv
module tb_auxdac_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic [1:0]  pmode = 2'd0;
    logic [35:0] aux_code;
    logic [2:0]  aux_enable;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    typedef struct {
        logic [35:0] code;
        logic [2:0]  en;
        string       req;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    logic [11:0] model [3];

    always #5 clk = ~clk;

    auxdac_bank dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .pmode(pmode), .aux_code(aux_code), .aux_enable(aux_enable)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: compute expected outputs from the requirements, push, notify
    task automatic expect_now(input string req);
        exp_t e;
        e.code = (pmode == 2'd3) ? 36'd0 : {model[2], model[1], model[0]};
        e.en   = (pmode == 2'd3) ? 3'b000 : 3'b111;
        e.req  = req;
        q.push_back(e);
        -> chk_ev;
        wait_clk(1);
    endtask

    // shift nbits of vec, MSB first; idle_hi selects the resting sclk level
    task automatic send_bits(input logic [31:0] vec, input int nbits, input bit idle_hi);
        sclk = idle_hi;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sclk = 1'b0;
            sdin = vec[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
        if (!idle_hi) begin
            sclk = 1'b0;
            wait_clk(4);
        end
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic write_ch(input logic [3:0] addr, input logic [11:0] code, input bit idle_hi);
        send_bits({16'd0, addr, code}, 16, idle_hi);
        if (addr >= 4'd1 && addr <= 4'd3) model[addr - 1] = code;
    endtask

    // monitor: pop expected items and compare with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (aux_code !== e.code || aux_enable !== e.en) begin
                    failures++;
                    $display("FAIL %s: code=%h en=%b expected code=%h en=%b",
                             e.req, aux_code, aux_enable, e.code, e.en);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model[0] = 12'd1555; model[1] = 12'd0; model[2] = 12'd0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        expect_now("R2 reset codes");

        write_ch(4'd2, 12'hABC, 1'b0);
        expect_now("R1 R3 R11 write ch2");
        write_ch(4'd1, 12'h001, 1'b0);
        expect_now("R1 R11 write ch1");
        write_ch(4'd3, 12'hFFF, 1'b0);
        expect_now("R11 write ch3");

        write_ch(4'd2, 12'h555, 1'b1);
        expect_now("R10 sclk idle high");
        write_ch(4'd1, 12'h7E1, 1'b1);
        expect_now("R10 second idle-high word");

        send_bits({16'd0, 4'd2, 12'h123} & 32'h7FFF, 15, 1'b0);
        expect_now("R4 15-bit word discarded");
        send_bits({15'd0, 1'b0, 4'd3, 12'h321}, 17, 1'b0);
        expect_now("R4 17-bit word discarded");

        write_ch(4'd0, 12'h0AA, 1'b0);
        expect_now("R5 address 0 ignored");
        write_ch(4'd7, 12'h0BB, 1'b0);
        expect_now("R5 address 7 ignored");

        pmode = 2'd1; wait_clk(3);
        expect_now("R7 idle holds");
        pmode = 2'd2; wait_clk(3);
        expect_now("R7 standby holds");

        pmode = 2'd3; wait_clk(3);
        expect_now("R6 shutdown zero");
        write_ch(4'd3, 12'h246, 1'b0);
        expect_now("R9 write in shutdown stays zero");
        pmode = 2'd0; wait_clk(3);
        expect_now("R8 R9 wake restores");

        pmode = 2'd3; wait_clk(3);
        expect_now("R6 second shutdown");
        pmode = 2'd2; wait_clk(3);
        expect_now("R8 wake into standby");

        wait_clk(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule